// File: doc/BRIEF.md
# Buffered Clock/Calendar Register Window

This block is the software-visible face of a battery-backed clock/calendar. It sits on a byte-wide memory-style bus and claims the eight highest addresses of an 11-bit address space. Behind those addresses it keeps a shadow copy of the time registers. The running counter chain is a separate block: it presents its current time on `liveTime`, and on each one-second `tick` that copy is merged into the shadow. Two control bits in the first window byte change this behaviour. The freeze bit stops the merge, so software can read a consistent snapshot while the counters keep running. The stage bit also stops the merge and lets software fill the registers with a new time. When software clears the stage bit, the block hands the staged time to the counter chain through `loadTime` and a one-cycle `loadStrobe`.

All bus inputs are taken as already synchronous to `clk`. A bus write is accepted on every rising edge at which the chip is selected, write is enabled and the address falls in the window. A bus read presents the addressed byte combinationally. The `inhibit` input models a supply-fail condition: while it is high, every access is refused.

Top module: `rtc_shadow_window`

## Requirements
- R1: Window index = address minus 0x7F8, and the window covers 0x7F8..0x7FF. The indices are 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. `dataOe` is high only when `chipEnN`=0, `outEnN`=0, `wrEnN`=1 and the address is in the window. A write with `chipEnN`=1 or with an address outside the window changes nothing.
- R2: On a `tick` with both halt bits clear, each byte's counter field is copied from `liveTime` (byte i at bits 8i+7:8i). The field masks are: index 0 0x3F, 1 0xFF, 2 0x7F, 3 0x3F, 4 0x47, 5 0x3F, 6 0x1F, 7 0xFF. Bits outside a mask are not taken from `liveTime`.
- R3: While the freeze bit (bit 6 of index 0) is 1, a `tick` leaves every byte unchanged.
- R4: After the freeze bit is written to 0, the next `tick` refreshes all bytes together.
- R5: While the stage bit (bit 7 of index 0) is 1, software writes are stored and a `tick` does not overwrite them.
- R6: A write to index 0 with bit 7 = 0 while the stage bit is 1 raises `loadStrobe` for exactly the one cycle after that write. During that cycle `loadTime` carries the masked staged fields (same layout and masks as R2).
- R7: Bit 7 of index 4 always reads as `battOk`. Writes to that bit are ignored.
- R8: Bits outside the R2 masks, except the two halt bits and the R7 flag, are ordinary storage. A refresh does not alter them.
- R9: While `inhibit` is 1, no write takes effect and `dataOe` stays 0.
- R10: If both halt bits are set, clearing only the freeze bit does not re-enable refresh. Refresh resumes, and the commit of R6 happens, only when the stage bit is cleared.
- R11: After reset every stored bit is 0, `loadStrobe` is 0, and index 4 reads as `battOk` in bit 7 with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEnN | input | 1 | Chip select, active low |
| outEnN | input | 1 | Output enable, active low |
| wrEnN | input | 1 | Write enable, active low |
| addr | input | 11 | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, zero when not driving |
| dataOe | output | 1 | Read data valid / bus drive enable |
| inhibit | input | 1 | Supply-fail access block |
| tick | input | 1 | One-second pulse from the counter chain |
| battOk | input | 1 | Backup source good |
| liveTime | input | 64 | Current counter values, byte i = window index i |
| loadTime | output | 64 | Masked shadow fields for loading the counters |
| loadStrobe | output | 1 | One-cycle load request to the counter chain |

## Verification
Refresh is driven by live values that carry extra bits outside each field mask. This separates correct masking from a plain byte copy. It also shows that storage bits written earlier survive a refresh. Ticks are issued in four control states: free running, frozen, staged, and both bits set. This tells apart a design that gates refresh on only one bit from one that gates on either. Commit is checked on the exact cycle after the clearing write, and on the cycle after that. This catches strobes that are late, stretched, or carry stale data. Reads outside the window, with output enable off, during inhibit, and with chip select high confirm that only a qualified access reaches the shadow.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;
  localparam int NumRegs = 8;
  localparam int IdxW    = $clog2(NumRegs);
  localparam int DataW   = 8;
  localparam int CtlIdx  = 0;
  localparam int DayIdx  = 4;
  localparam int StageBit  = 7;
  localparam int FreezeBit = 6;
  localparam int BattBit   = 7;

  typedef struct packed {
    logic            rdEn;
    logic            wrEn;
    logic [IdxW-1:0] idx;
    logic            refresh;
    logic            commit;
  } winStrobes_t;

  // Bits of each byte that belong to the counter chain
  function automatic logic [DataW-1:0] fieldMask(input int idx);
    case (idx)
      0:       return 8'h3F;
      1:       return 8'hFF;
      2:       return 8'h7F;
      3:       return 8'h3F;
      4:       return 8'h47;
      5:       return 8'h3F;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_win_ctl.sv
module rtc_win_ctl
  import rtc_win_pkg::*;
#(
  parameter int AddrW = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEnN,
  input  logic             outEnN,
  input  logic             wrEnN,
  input  logic [AddrW-1:0] addr,
  input  logic             stageIn,
  input  logic             inhibit,
  input  logic             tick,
  input  logic             haltRd,
  input  logic             haltWr,
  output winStrobes_t      st,
  output logic             loadStrobe
);
  logic inWindow;
  logic selected;

  assign inWindow = &addr[AddrW-1:IdxW];
  assign selected = !chipEnN && inWindow && !inhibit;

  always_comb begin
    st.idx     = addr[IdxW-1:0];
    st.wrEn    = selected && !wrEnN;
    st.rdEn    = selected && wrEnN && !outEnN;
    st.refresh = tick && !haltRd && !haltWr;
    st.commit  = st.wrEn && (st.idx == IdxW'(CtlIdx)) && haltWr && !stageIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadStrobe <= 1'b0;
    else       loadStrobe <= st.commit;
  end
endmodule

// File: rtl/rtc_win_dp.sv
module rtc_win_dp
  import rtc_win_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  winStrobes_t              st,
  input  logic [DataW-1:0]         dataIn,
  input  logic                     battOk,
  input  logic [NumRegs*DataW-1:0] liveTime,
  output logic [DataW-1:0]         dataOut,
  output logic                     haltRd,
  output logic                     haltWr,
  output logic [NumRegs*DataW-1:0] loadTime
);
  logic [DataW-1:0] shadow [NumRegs];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumRegs; i++) shadow[i] <= '0;
    end else begin
      for (int i = 0; i < NumRegs; i++) begin
        if (st.wrEn && st.idx == IdxW'(i)) begin
          shadow[i] <= (i == DayIdx) ? (dataIn & ~(DataW'(1) << BattBit)) : dataIn;
        end else if (st.refresh) begin
          shadow[i] <= (shadow[i] & ~fieldMask(i)) | (liveTime[DataW*i +: DataW] & fieldMask(i));
        end
      end
    end
  end

  assign haltRd = shadow[CtlIdx][FreezeBit];
  assign haltWr = shadow[CtlIdx][StageBit];

  for (genvar g = 0; g < NumRegs; g++) begin : g_load
    assign loadTime[DataW*g +: DataW] = shadow[g] & fieldMask(g);
  end

  always_comb begin
    dataOut = '0;
    if (st.rdEn) begin
      dataOut = shadow[st.idx];
      if (st.idx == IdxW'(DayIdx)) dataOut[BattBit] = battOk;
    end
  end
endmodule

// File: rtl/rtc_shadow_window.sv
module rtc_shadow_window
  import rtc_win_pkg::*;
#(
  parameter int AddrW = 11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     chipEnN,
  input  logic                     outEnN,
  input  logic                     wrEnN,
  input  logic [AddrW-1:0]         addr,
  input  logic [DataW-1:0]         dataIn,
  output logic [DataW-1:0]         dataOut,
  output logic                     dataOe,
  input  logic                     inhibit,
  input  logic                     tick,
  input  logic                     battOk,
  input  logic [NumRegs*DataW-1:0] liveTime,
  output logic [NumRegs*DataW-1:0] loadTime,
  output logic                     loadStrobe
);
  winStrobes_t st;
  logic haltRd;
  logic haltWr;

  rtc_win_ctl #(.AddrW(AddrW)) i_ctl (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN), .wrEnN(wrEnN),
    .addr(addr), .stageIn(dataIn[StageBit]), .inhibit(inhibit), .tick(tick),
    .haltRd(haltRd), .haltWr(haltWr), .st(st), .loadStrobe(loadStrobe)
  );

  rtc_win_dp i_dp (
    .clk(clk), .rstN(rstN), .st(st), .dataIn(dataIn), .battOk(battOk),
    .liveTime(liveTime), .dataOut(dataOut), .haltRd(haltRd), .haltWr(haltWr),
    .loadTime(loadTime)
  );

  assign dataOe = st.rdEn;
endmodule

// File: rtl/rtc_shadow_window_chk.sv
module rtc_shadow_window_chk #(
  parameter int AddrW = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             chipEnN,
  input logic             outEnN,
  input logic             wrEnN,
  input logic [AddrW-1:0] addr,
  input logic             inhibit,
  input logic             dataOe,
  input logic             loadStrobe,
  input logic             haltRd,
  input logic             haltWr,
  input logic             wrEn,
  input logic [63:0]      loadTime
);
  // R1
  read_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!chipEnN && !outEnN && wrEnN && (&addr[AddrW-1:3])));

  // R9
  inhibit_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |-> !dataOe);

  // R9
  inhibit_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inhibit && (haltRd || haltWr)) |=> $stable(loadTime));

  // R3
  halted_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && (haltRd || haltWr)) |=> $stable(loadTime));

  // R6
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe);

  // R6
  load_after_stage_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> !haltWr);
endmodule

bind rtc_shadow_window rtc_shadow_window_chk #(.AddrW(AddrW)) i_chk (
  .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN), .wrEnN(wrEnN),
  .addr(addr), .inhibit(inhibit), .dataOe(dataOe), .loadStrobe(loadStrobe),
  .haltRd(haltRd), .haltWr(haltWr), .wrEn(st.wrEn), .loadTime(loadTime)
);

// File: tb/test_rtc_shadow_window.sv
`timescale 1ns/1ps
module test_rtc_shadow_window;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipEnN = 1'b1, outEnN = 1'b1, wrEnN = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic        inhibit = 1'b0, tick = 1'b0, battOk = 1'b1;
  logic [63:0] liveTime = '0;
  logic [63:0] loadTime;
  logic        loadStrobe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // byte order: year month date day hours minutes seconds century
  localparam logic [63:0] Live1 = 64'h24_02_28_83_D2_B0_45_20;
  localparam logic [63:0] Live2 = 64'h24_02_28_83_D2_B1_46_20;

  always #5 clk = ~clk;

  rtc_shadow_window i_rtc_shadow_window (.*);

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wrAt(input logic [10:0] a, input logic [7:0] d, input logic ce = 1'b0);
    @(negedge clk);
    addr = a; dataIn = d; chipEnN = ce; wrEnN = 1'b0; outEnN = 1'b1;
    @(negedge clk);
    chipEnN = 1'b1; wrEnN = 1'b1;
  endtask

  task automatic rdAt(input logic [10:0] a, input logic oe, output logic [7:0] v, output logic en);
    @(negedge clk);
    addr = a; chipEnN = 1'b0; wrEnN = 1'b1; outEnN = oe;
    #1 v = dataOut; en = dataOe;
    chipEnN = 1'b1; outEnN = 1'b1;
  endtask

  task automatic expRd(input string req, input int idx, input logic [7:0] exp);
    logic [7:0] v; logic en;
    rdAt(11'h7F8 + 11'(idx), 1'b0, v, en);
    chk(req, {en, v}, {1'b1, exp});
  endtask

  task automatic pulseTick(input logic [63:0] live);
    @(negedge clk); liveTime = live; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic testReset;
    chk("R11 loadStrobe", loadStrobe, 0);
    expRd("R11 ctl", 0, 8'h00);
    expRd("R11 day", 4, 8'h80);
    expRd("R11 year", 7, 8'h00);
  endtask

  task automatic testRefresh;
    pulseTick(Live1);
    expRd("R2 century", 0, 8'h20);
    expRd("R2 seconds", 1, 8'h45);
    expRd("R2 minutes", 2, 8'h30);
    expRd("R2 hours", 3, 8'h12);
    expRd("R2 day", 4, 8'h83);
    expRd("R2 month", 6, 8'h02);
    expRd("R2 year", 7, 8'h24);
  endtask

  task automatic testStorageAndFlag;
    wrAt(11'h7FA, 8'h91);
    battOk = 1'b0;
    wrAt(11'h7FC, 8'hB8);
    expRd("R7 flag low", 4, 8'h38);
    battOk = 1'b1;
    expRd("R7 flag high", 4, 8'hB8);
    pulseTick(Live1);
    expRd("R8 minutes", 2, 8'hB0);
    expRd("R8 day", 4, 8'hBB);
  endtask

  task automatic testFreeze;
    wrAt(11'h7F8, 8'h60);
    pulseTick(Live2);
    expRd("R3 seconds", 1, 8'h45);
    expRd("R3 ctl", 0, 8'h60);
    wrAt(11'h7F8, 8'h20);
    pulseTick(Live2);
    expRd("R4 seconds", 1, 8'h46);
    expRd("R4 minutes", 2, 8'hB1);
  endtask

  task automatic testStage;
    wrAt(11'h7F8, 8'hA0);
    wrAt(11'h7F9, 8'h15);
    wrAt(11'h7FB, 8'h08);
    pulseTick(Live2);
    expRd("R5 seconds", 1, 8'h15);
    expRd("R5 hours", 3, 8'h08);
    @(negedge clk);
    addr = 11'h7F8; dataIn = 8'h21; chipEnN = 1'b0; wrEnN = 1'b0;
    @(negedge clk);
    chipEnN = 1'b1; wrEnN = 1'b1;
    chk("R6 strobe", loadStrobe, 1);
    chk("R6 loadTime", loadTime[31:0], 32'h08_31_15_21);
    @(negedge clk);
    chk("R6 strobe end", loadStrobe, 0);
    expRd("R6 ctl", 0, 8'h21);
  endtask

  task automatic testBoth;
    wrAt(11'h7F8, 8'hC0);
    pulseTick(Live2);
    expRd("R10 ctl held", 0, 8'hC0);
    wrAt(11'h7F8, 8'h80);
    pulseTick(Live2);
    expRd("R10 seconds held", 1, 8'h15);
    @(negedge clk);
    addr = 11'h7F8; dataIn = 8'h00; chipEnN = 1'b0; wrEnN = 1'b0;
    @(negedge clk);
    chipEnN = 1'b1; wrEnN = 1'b1;
    chk("R10 commit", loadStrobe, 1);
    pulseTick(Live2);
    expRd("R10 seconds live", 1, 8'h46);
    expRd("R10 ctl live", 0, 8'h20);
  endtask

  task automatic testInhibitAndWindow;
    logic [7:0] v; logic en;
    inhibit = 1'b1;
    wrAt(11'h7FF, 8'h99);
    rdAt(11'h7FF, 1'b0, v, en);
    chk("R9 no drive", en, 0);
    inhibit = 1'b0;
    expRd("R9 year kept", 7, 8'h24);
    rdAt(11'h7F7, 1'b0, v, en);
    chk("R1 outside", {en, v}, 9'h000);
    rdAt(11'h7FF, 1'b1, v, en);
    chk("R1 oe off", en, 0);
    wrAt(11'h7FF, 8'h77, 1'b1);
    wrAt(11'h7F7, 8'h77);
    expRd("R1 year kept", 7, 8'h24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRefresh();
    testStorageAndFlag();
    testFreeze();
    testStage();
    testBoth();
    testInhibitAndWindow();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule